// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This host-side engine waits for a program or erase operation on a parallel flash device to finish. It receives a one-cycle start pulse, the target address and the data value the location should hold afterwards. It then reads that address repeatedly over a simple request/acknowledge read port. While the device is busy, the toggle bit changes value on every read. The operation is over when two reads in a row return the same toggle-bit value.

When toggling stops, the engine makes one more read. That read returns the stored data, or all ones after an erase. The engine compares it with the expected value. If a read shows the error bit set while the toggle bit is still changing, the engine makes two confirmation reads before it decides between failure and success. A read budget bounds the whole poll.

The engine reports completion with a one-cycle done pulse. At the same time it raises exactly one of pass, fail or timeout, plus a separate mismatch flag. These results stay held until the next start.

Top module: `tbit_poller`

## Requirements
- R1: A start pulse while idle latches the address and the expected value, and every read of the poll uses that address. A start pulse that arrives while busy is ignored: it changes neither the address nor the result, and it does not produce a second done.
- R2: A read request stays high until it is acknowledged. The read data is taken in the cycle in which the acknowledge is high.
- R3: When two consecutive status reads return the same toggle bit (bit 6), the engine issues one further read. It reports that read as the final data, raises pass and pulses done.
- R4: The final data is compared with the expected value, and the mismatch flag is raised when they differ. The mismatch flag is only ever high together with pass.
- R5: If a status read's toggle bit differs from the previous read's and its error bit (bit 5) is 1, the engine makes exactly two more reads. If their toggle bits differ, it reports fail with no further read. If they match, it makes one final read and reports pass as in R3.
- R6: If the toggle bit still differs, with the error bit clear, on status read number MAX_READS (counting from the first read), the engine stops without further reads and reports timeout.
- R7: If the read that exhausts the budget also carries the error bit, the two confirmation reads of R5 take priority over the timeout.
- R8: After reset the engine is idle, with busy, done and read request low. Done is a single-cycle pulse, and at done exactly one of pass, fail and timeout is high. The result flags hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start pulse |
| addr_i | input | AW | Address to poll |
| expect_i | input | DW | Data expected after completion |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DW | Read data |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pass_o | output | 1 | Operation finished without error |
| fail_o | output | 1 | Error confirmed by toggling continuing |
| tmo_o | output | 1 | Read budget exhausted |
| mismatch_o | output | 1 | Final data differs from expected |
| final_o | output | DW | Data of the final read |

## Verification
Two decisions can fall on the same status read: the budget running out (R6) and the error bit asking for confirmation reads (R5). A case with the error bit first appearing exactly on read MAX_READS provokes this collision. The bench then requires a fail result after two extra reads, not a timeout (R7). A reference walk over the same device read sequence predicts the result flags, the final data and the exact number of reads for every case. A scoreboard compares these predictions with the done outputs.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_POLL,
    ST_ECHK1,
    ST_ECHK2,
    ST_FINAL
  } poll_st_t;
endpackage

// File: rtl/poll_rdport.sv
module poll_rdport #(
  parameter int AW = 18,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          got_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
      got_o     <= 1'b0;
      data_o    <= '0;
    end else begin
      got_o <= 1'b0;
      if (rd_req_o && rd_ack_i) begin
        rd_req_o <= 1'b0;
        got_o    <= 1'b1;
        data_o   <= rd_data_i;
      end else if (go_i) begin
        rd_req_o  <= 1'b1;
        rd_addr_o <= addr_i;
      end
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_o && !rd_ack_i |=> rd_req_o);

  // R2
  got_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_o && rd_ack_i |=> got_o && !rd_req_o);
endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt <= '0;
    else if (inc_i && cnt != CW'(LIMIT)) cnt <= cnt + 1'b1;
  end

  // budget used up once this read completes
  assign hit_o = (cnt >= CW'(LIMIT - 1));
endmodule

// File: rtl/tbit_poller.sv
module tbit_poller #(
  parameter int AW        = 18,
  parameter int DW        = 8,
  parameter int MAX_READS = 16,
  parameter int TOG_BIT   = 6,
  parameter int ERR_BIT   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] expect_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          pass_o,
  output logic          fail_o,
  output logic          tmo_o,
  output logic          mismatch_o,
  output logic [DW-1:0] final_o
);
  import poll_pkg::*;

  poll_st_t      st;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic          go, got, hit, prev_tog;
  logic [DW-1:0] rdat;

  poll_rdport #(.AW(AW), .DW(DW)) u_port (
    .clk(clk), .rst(rst), .go_i(go), .addr_i(addr_q),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .got_o(got), .data_o(rdat)
  );

  poll_budget #(.LIMIT(MAX_READS)) u_budget (
    .clk(clk), .rst(rst), .clr_i(st == ST_IDLE),
    .inc_i(got), .hit_o(hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      addr_q     <= '0;
      exp_q      <= '0;
      go         <= 1'b0;
      prev_tog   <= 1'b0;
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      pass_o     <= 1'b0;
      fail_o     <= 1'b0;
      tmo_o      <= 1'b0;
      mismatch_o <= 1'b0;
      final_o    <= '0;
    end else begin
      go     <= 1'b0;
      done_o <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          addr_q     <= addr_i;
          exp_q      <= expect_i;
          go         <= 1'b1;
          busy_o     <= 1'b1;
          pass_o     <= 1'b0;
          fail_o     <= 1'b0;
          tmo_o      <= 1'b0;
          mismatch_o <= 1'b0;
          st         <= ST_FIRST;
        end
        ST_FIRST: if (got) begin
          prev_tog <= rdat[TOG_BIT];
          go       <= 1'b1;
          st       <= ST_POLL;
        end
        ST_POLL: if (got) begin
          if (rdat[TOG_BIT] == prev_tog) begin
            go <= 1'b1;
            st <= ST_FINAL;
          end else if (rdat[ERR_BIT]) begin
            go <= 1'b1;
            st <= ST_ECHK1;
          end else if (hit) begin
            tmo_o  <= 1'b1;
            done_o <= 1'b1;
            busy_o <= 1'b0;
            st     <= ST_IDLE;
          end else begin
            prev_tog <= rdat[TOG_BIT];
            go       <= 1'b1;
          end
        end
        ST_ECHK1: if (got) begin
          prev_tog <= rdat[TOG_BIT];
          go       <= 1'b1;
          st       <= ST_ECHK2;
        end
        ST_ECHK2: if (got) begin
          if (rdat[TOG_BIT] != prev_tog) begin
            fail_o <= 1'b1;
            done_o <= 1'b1;
            busy_o <= 1'b0;
            st     <= ST_IDLE;
          end else begin
            go <= 1'b1;
            st <= ST_FINAL;
          end
        end
        ST_FINAL: if (got) begin
          final_o    <= rdat;
          mismatch_o <= (rdat != exp_q);
          pass_o     <= 1'b1;
          done_o     <= 1'b1;
          busy_o     <= 1'b0;
          st         <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $countones({pass_o, fail_o, tmo_o}) == 1);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R4
  mismatch_pass_chk: assert property (@(posedge clk) disable iff (rst)
    mismatch_o |-> pass_o);

  // R1
  req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> busy_o);

  // R8
  held_result_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o && !start_i |=> $stable({pass_o, fail_o, tmo_o, mismatch_o}));
endmodule

// File: tb/sim_tbit_poller.sv
`timescale 1ns/1ps
module sim_tbit_poller;
  localparam int AW  = 18;
  localparam int DW  = 8;
  localparam int MAX = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] expect_i = '0;
  logic rd_req_o, rd_ack_i;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data_i;
  logic busy_o, done_o, pass_o, fail_o, tmo_o, mismatch_o;
  logic [DW-1:0] final_o;

  always #2 clk = ~clk;

  tbit_poller #(.AW(AW), .DW(DW), .MAX_READS(MAX)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i),
    .expect_i(expect_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o), .tmo_o(tmo_o),
    .mismatch_o(mismatch_o), .final_o(final_o)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model: toggles for ntog reads, error bit from read errat on
  int ntog = 1, errat = 999, rcnt = 0, dly = 0;
  logic [DW-1:0] fv = '0;
  logic [AW-1:0] cur_addr = '0;

  function automatic logic [DW-1:0] dat(int r);
    logic [DW-1:0] d;
    d = '0;
    if (r < ntog) begin
      d[6] = r[0];
      d[5] = (r >= errat);
    end else if (r == ntog) begin
      d[6] = ~ntog[0];
      d[5] = (r >= errat);
    end else d = fv;
    return d;
  endfunction

  typedef struct {
    bit p, f, t, m;
    logic [DW-1:0] fd;
    int nreads;
  } exp_t;
  exp_t sb[$];

  function automatic exp_t ref_run(logic [DW-1:0] ex);
    exp_t e;
    int r;
    logic prev;
    logic [DW-1:0] d;
    e = '{p:0, f:0, t:0, m:0, fd:'0, nreads:0};
    prev = dat(0)[6];
    r = 1;
    while (1) begin
      d = dat(r);
      if (d[6] == prev) begin
        e.p = 1; e.fd = dat(r + 1); e.nreads = r + 2; break;
      end else if (d[5]) begin
        if (dat(r + 1)[6] != dat(r + 2)[6]) begin
          e.f = 1; e.nreads = r + 3;
        end else begin
          e.p = 1; e.fd = dat(r + 3); e.nreads = r + 4;
        end
        break;
      end else if (r + 1 >= MAX) begin
        e.t = 1; e.nreads = r + 1; break;
      end
      prev = d[6];
      r++;
    end
    e.m = e.p && (e.fd != ex);
    return e;
  endfunction

  // read responder (R2): ack after 0..2 idle cycles, one cycle wide
  always @(negedge clk) begin
    if (rst) begin
      rd_ack_i  = 1'b0;
      rd_data_i = '0;
    end else if (rd_ack_i) begin
      rd_ack_i = 1'b0;
    end else if (rd_req_o) begin
      if (dly == 0) begin
        chk(rd_addr_o == cur_addr, "R1 read address", int'(rd_addr_o), int'(cur_addr));
        rd_data_i = dat(rcnt);
        rd_ack_i  = 1'b1;
        rcnt++;
        dly = rcnt % 3;
      end else dly--;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (sb.size() == 0) chk(0, "R1 spurious done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk(pass_o == e.p, "R3 pass flag", pass_o, e.p);
        chk(fail_o == e.f, "R5 fail flag", fail_o, e.f);
        chk(tmo_o == e.t, "R6 timeout flag", tmo_o, e.t);
        chk(mismatch_o == e.m, "R4 mismatch", mismatch_o, e.m);
        if (e.p) chk(final_o == e.fd, "R3 final data", final_o, e.fd);
        chk(rcnt == e.nreads, "R7 read count", rcnt, e.nreads);
      end
    end
  end

  task automatic run(int nt, int ea, logic [DW-1:0] f, logic [DW-1:0] ex,
                     logic [AW-1:0] a, bit poke);
    exp_t e;
    bit p0, f0, t0;
    ntog = nt; errat = ea; fv = f; rcnt = 0; dly = 1; cur_addr = a;
    e = ref_run(ex);
    sb.push_back(e);
    @(negedge clk);
    start_i = 1'b1; addr_i = a; expect_i = ex;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1; addr_i = ~a; expect_i = ~ex;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    p0 = pass_o; f0 = fail_o; t0 = tmo_o;
    @(negedge clk);
    chk(!done_o, "R8 done single cycle", done_o, 0);
    chk(sb.size() == 0, "R8 result consumed", sb.size(), 0);
    repeat (4) @(negedge clk);
    chk({pass_o, fail_o, tmo_o} == {p0, f0, t0}, "R8 result held",
        {pass_o, fail_o, tmo_o}, {p0, f0, t0});
    chk(!busy_o && !done_o, "R1 no second run", {busy_o, done_o}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !rd_req_o, "R8 reset idle",
        {busy_o, done_o, rd_req_o}, 0);
    run(5, 999, 8'hA5, 8'hA5, 18'h00555, 0);  // R3 normal program
    run(4, 999, 8'h3C, 8'h3D, 18'h01234, 0);  // R4 data mismatch
    run(7, 999, 8'hFF, 8'hFF, 18'h3FFFF, 0);  // R3 erase to ones
    run(1, 999, 8'h12, 8'h12, 18'h00001, 0);  // R3 stops at once
    run(999, 999, 8'h00, 8'h00, 18'h00AAA, 0); // R6 timeout
    run(999, 3, 8'h00, 8'h00, 18'h02000, 0);  // R5 confirmed failure
    run(4, 3, 8'hC3, 8'hC3, 18'h02100, 0);    // R5 error then recovery
    run(999, MAX - 1, 8'h00, 8'h00, 18'h1F000, 0); // R7 error beats budget
    run(999, MAX - 2, 8'h00, 8'h00, 18'h1F001, 0); // R5 error just before limit
    run(6, 999, 8'h5A, 8'h5A, 18'h12345, 1);  // R1 start while busy ignored
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule